// File: doc/BRIEF.md
# Cache-Line Instruction Extractor

This block sits in the front end of an instruction pipeline. Each cycle that it is asked to fetch, it takes one 64-byte instruction-cache line and the current fetch PC. It cuts the line into 32-bit instruction words, starting at the word the PC points to. It then fills a parallel array of slots that goes to the decoder. Every filled slot carries the raw word, its PC, a sequence number from a running counter, and the PC predicted to follow it. A per-slot predictor interface supplies, for each slot position, whether the word is a control instruction, whether it is predicted taken, and its predicted target. A per-slot pre-decode flag marks quiesce instructions.

A group ends at the first of four limits: the configured slot count, the end of the line, a predicted-taken branch, or a quiesce instruction. The block registers the PC the thread should fetch next and keeps a small thread state. A quiesce instruction parks the thread in a quiescent state. A translation fault replaces the whole group with one placeholder no-op that carries the fault code, and parks the thread in a trap state. A restart pulse from the squash logic returns the thread to running.

Top module: `line_inst_extractor`

## Requirements
- R1: After reset no slot is valid, the group count and `wrote_out` are 0, `thr_state` is 0 (running), `upd_pc` is `RESET_PC` and `upd_npc` is `RESET_PC`+4, the branch and taken counters are 0, and the first sequence number handed out is 0.
- R2: `line_addr` equals `fetch_pc` with bits [5:0] cleared, combinationally.
- R3: The group starts at word index `fetch_pc[5:2]`. Slot k holds line word (start+k), where word j is `line_data[32*j +: 32]`. The first slot's PC is `fetch_pc` with bits [1:0] cleared. Results appear on the outputs one clock after the `fetch_go` edge.
- R4: The slot count never exceeds parameter `W`, and no slot is filled past word 15 of the line.
- R5: For a slot whose `pr_ctrl` bit is 0, the predicted next PC is its PC + 4. Each following slot's PC equals the previous slot's predicted next PC.
- R6: For a slot whose `pr_ctrl` bit is 1, the predicted next PC is its `pr_target` field. If its `pr_taken` bit is also 1, that slot is the last of the group. `br_count` grows by the number of control slots emitted and `taken_count` by the number of taken control slots emitted.
- R7: A slot whose `pr_quiesce` bit is 1 is emitted and counted, ends the group, and sets `thr_state` to 1 (quiescent).
- R8: With `fault_valid` high, line data and predictor inputs are ignored. Exactly slot 0 is filled with word `NOP_WORD`, the aligned fetch PC, a next PC of that PC + 4, `slot_fault` high and `slot_fault_code` equal to `fault_code`. `thr_state` becomes 2 (trap), and `upd_pc`/`upd_npc` keep their values.
- R9: After a fault-free group with at least one slot, `upd_pc` equals the last slot's predicted next PC and `upd_npc` equals that value + 4.
- R10: Sequence numbers increase by one per emitted slot (faulting no-op included), consecutively within and across groups, modulo 2^`SEQ_W`.
- R11: `wrote_out` is high exactly in the cycles in which at least one slot is valid.
- R12: While `thr_state` is not 0, `fetch_go` has no effect: no slot, and no change to PC, sequence or counters. `restart` sets `thr_state` to 0 and overrides a `fetch_go` in the same cycle.
- R13: Without `fetch_go`, all slots are invalid in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Return thread to running, drop this cycle's fetch |
| fetch_go | input | 1 | Extract a group this cycle |
| fetch_pc | input | AW | Current fetch PC |
| line_data | input | 512 | Cache line, word j at bits [32j+31:32j] |
| fault_valid | input | 1 | Translation fault for this fetch |
| fault_code | input | FW | Fault code to attach |
| pr_ctrl | input | W | Per slot: control instruction |
| pr_taken | input | W | Per slot: predicted taken |
| pr_target | input | W*AW | Per slot: predicted target |
| pr_quiesce | input | W | Per slot: quiesce instruction |
| line_addr | output | AW | Line request address |
| slot_valid | output | W | Slot filled |
| slot_inst | output | W*32 | Slot instruction word |
| slot_pc | output | W*AW | Slot PC |
| slot_npc | output | W*AW | Slot predicted next PC |
| slot_seq | output | W*SEQ_W | Slot sequence number |
| slot_fault | output | 1 | Slot 0 is a fault carrier |
| slot_fault_code | output | FW | Carried fault code |
| wrote_out | output | 1 | At least one slot filled |
| group_count | output | $clog2(W+1) | Number of filled slots |
| upd_pc | output | AW | PC for the next fetch |
| upd_npc | output | AW | upd_pc + 4 |
| thr_state | output | 2 | 0 running, 1 quiescent, 2 trap |
| br_count | output | CNT_W | Emitted control instructions |
| taken_count | output | CNT_W | Emitted predicted-taken instructions |

## Verification
A wrong start offset or a broken stop chain shows in the very next cycle, as wrong words, a wrong slot count or a wrong last-slot PC. A sequence counter that slips is quieter: it stays hidden until the next group. From then on every later group is offset, so the comparison against a running model catches it on the first emission after the error. A thread state that fails to park, or fails to leave the parked state, appears only when a later `fetch_go` or `restart` arrives, so the stimulus pairs every quiesce and fault with both.

// File: rtl/xtr_pkg.sv
package xtr_pkg;

    localparam int LINE_BYTES  = 64;
    localparam int INST_BYTES  = 4;
    localparam int LINE_WORDS  = LINE_BYTES / INST_BYTES;
    localparam int WORD_IDX_W  = $clog2(LINE_WORDS);
    localparam int LINE_BITS   = LINE_BYTES * 8;
    localparam int INST_BITS   = INST_BYTES * 8;
    localparam int OFS_LSB     = $clog2(INST_BYTES);
    localparam int OFS_MSB     = $clog2(LINE_BYTES) - 1;

    typedef enum logic [1:0] {
        THR_RUN     = 2'd0,
        THR_QUIESCE = 2'd1,
        THR_TRAP    = 2'd2
    } thr_state_e;

endpackage

// File: rtl/xtr_word_pick.sv
module xtr_word_pick
    import xtr_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [LINE_BITS-1:0]    line,
    input  logic [WORD_IDX_W-1:0]   start_idx,
    output logic [W*INST_BITS-1:0]  words,
    output logic [W-1:0]            in_line
);

    localparam int IDX_EXT_W = WORD_IDX_W + 2;

    genvar k;
    generate
        for (k = 0; k < W; k++) begin : g_slot
            logic [IDX_EXT_W-1:0] idx_ext;
            logic [WORD_IDX_W-1:0] idx;
            assign idx_ext = IDX_EXT_W'(start_idx) + IDX_EXT_W'(k);
            assign idx     = idx_ext[WORD_IDX_W-1:0];
            assign in_line[k] = (idx_ext < IDX_EXT_W'(LINE_WORDS));
            assign words[k*INST_BITS +: INST_BITS] =
                in_line[k] ? line[idx*INST_BITS +: INST_BITS] : '0;
        end
    endgenerate

endmodule

// File: rtl/xtr_chain.sv
module xtr_chain
    import xtr_pkg::*;
#(
    parameter int W  = 4,
    parameter int AW = 32,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [AW-1:0]   start_pc,
    input  logic [W-1:0]    in_line,
    input  logic [W-1:0]    is_ctrl,
    input  logic [W-1:0]    is_taken,
    input  logic [W*AW-1:0] target,
    input  logic [W-1:0]    is_quiesce,
    output logic [W-1:0]    emit,
    output logic [W*AW-1:0] pc_out,
    output logic [W*AW-1:0] npc_out,
    output logic [AW-1:0]   end_pc,
    output logic [CW-1:0]   n_emit,
    output logic [CW-1:0]   n_ctrl,
    output logic [CW-1:0]   n_taken,
    output logic            saw_quiesce
);

    logic [AW-1:0] cur;
    logic [AW-1:0] nxt;
    logic          stop;

    always_comb begin
        emit        = '0;
        pc_out      = '0;
        npc_out     = '0;
        n_emit      = '0;
        n_ctrl      = '0;
        n_taken     = '0;
        saw_quiesce = 1'b0;
        stop        = 1'b0;
        cur         = start_pc;
        nxt         = start_pc;
        for (int k = 0; k < W; k++) begin
            if (!stop && in_line[k]) begin
                emit[k] = 1'b1;
                nxt = is_ctrl[k] ? target[k*AW +: AW] : cur + AW'(INST_BYTES);
                pc_out[k*AW +: AW]  = cur;
                npc_out[k*AW +: AW] = nxt;
                n_emit = n_emit + CW'(1);
                if (is_ctrl[k]) begin
                    n_ctrl = n_ctrl + CW'(1);
                    if (is_taken[k]) begin
                        n_taken = n_taken + CW'(1);
                        stop    = 1'b1;
                    end
                end
                if (is_quiesce[k]) begin
                    saw_quiesce = 1'b1;
                    stop        = 1'b1;
                end
                cur = nxt;
            end
        end
        end_pc = cur;
    end

endmodule

// File: rtl/line_inst_extractor.sv
module line_inst_extractor
    import xtr_pkg::*;
#(
    parameter int          W        = 4,
    parameter int          AW       = 32,
    parameter int          SEQ_W    = 16,
    parameter int          CNT_W    = 16,
    parameter int          FW       = 4,
    parameter logic [31:0] NOP_WORD = 32'h0000_0013,
    parameter logic [31:0] RESET_PC = 32'h0000_1000,
    localparam int         CW       = $clog2(W + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  restart,
    input  logic                  fetch_go,
    input  logic [AW-1:0]         fetch_pc,
    input  logic [LINE_BITS-1:0]  line_data,
    input  logic                  fault_valid,
    input  logic [FW-1:0]         fault_code,
    input  logic [W-1:0]          pr_ctrl,
    input  logic [W-1:0]          pr_taken,
    input  logic [W*AW-1:0]       pr_target,
    input  logic [W-1:0]          pr_quiesce,
    output logic [AW-1:0]         line_addr,
    output logic [W-1:0]          slot_valid,
    output logic [W*INST_BITS-1:0] slot_inst,
    output logic [W*AW-1:0]       slot_pc,
    output logic [W*AW-1:0]       slot_npc,
    output logic [W*SEQ_W-1:0]    slot_seq,
    output logic                  slot_fault,
    output logic [FW-1:0]         slot_fault_code,
    output logic                  wrote_out,
    output logic [CW-1:0]         group_count,
    output logic [AW-1:0]         upd_pc,
    output logic [AW-1:0]         upd_npc,
    output logic [1:0]            thr_state,
    output logic [CNT_W-1:0]      br_count,
    output logic [CNT_W-1:0]      taken_count
);

    typedef struct packed {
        logic [W-1:0]           valid;
        logic [W*INST_BITS-1:0] inst;
        logic [W*AW-1:0]        pc;
        logic [W*AW-1:0]        npc;
        logic [W*SEQ_W-1:0]     seq;
        logic                   fault;
        logic [FW-1:0]          fcode;
        logic                   wrote;
        logic [CW-1:0]          count;
        logic [AW-1:0]          upc;
        logic [AW-1:0]          unpc;
        thr_state_e             state;
        logic [SEQ_W-1:0]       seq_next;
        logic [CNT_W-1:0]       br;
        logic [CNT_W-1:0]       tk;
    } xtr_regs_t;

    xtr_regs_t r_d, r_q;

    logic [AW-1:0]          pc_al;
    logic [WORD_IDX_W-1:0]  start_idx;
    logic [W*INST_BITS-1:0] picked;
    logic [W-1:0]           in_line;
    logic [W-1:0]           ch_emit;
    logic [W*AW-1:0]        ch_pc;
    logic [W*AW-1:0]        ch_npc;
    logic [AW-1:0]          ch_end;
    logic [CW-1:0]          ch_n;
    logic [CW-1:0]          ch_nctrl;
    logic [CW-1:0]          ch_ntaken;
    logic                   ch_quiesce;

    assign pc_al     = {fetch_pc[AW-1:OFS_LSB], {OFS_LSB{1'b0}}};
    assign start_idx = fetch_pc[OFS_MSB:OFS_LSB];
    assign line_addr = {fetch_pc[AW-1:OFS_MSB+1], {(OFS_MSB+1){1'b0}}};

    xtr_word_pick #(.W(W)) u_pick (
        .line      (line_data),
        .start_idx (start_idx),
        .words     (picked),
        .in_line   (in_line)
    );

    xtr_chain #(.W(W), .AW(AW)) u_chain (
        .start_pc    (pc_al),
        .in_line     (in_line),
        .is_ctrl     (pr_ctrl),
        .is_taken    (pr_taken),
        .target      (pr_target),
        .is_quiesce  (pr_quiesce),
        .emit        (ch_emit),
        .pc_out      (ch_pc),
        .npc_out     (ch_npc),
        .end_pc      (ch_end),
        .n_emit      (ch_n),
        .n_ctrl      (ch_nctrl),
        .n_taken     (ch_ntaken),
        .saw_quiesce (ch_quiesce)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = '0;
        r_d.inst  = '0;
        r_d.pc    = '0;
        r_d.npc   = '0;
        r_d.seq   = '0;
        r_d.fault = 1'b0;
        r_d.fcode = '0;
        r_d.wrote = 1'b0;
        r_d.count = '0;
        if (restart) begin
            r_d.state = THR_RUN;
        end else if (fetch_go && r_q.state == THR_RUN) begin
            if (fault_valid) begin
                r_d.valid[0]               = 1'b1;
                r_d.inst[0 +: INST_BITS]   = NOP_WORD;
                r_d.pc[0 +: AW]            = pc_al;
                r_d.npc[0 +: AW]           = pc_al + AW'(INST_BYTES);
                r_d.seq[0 +: SEQ_W]        = r_q.seq_next;
                r_d.fault                  = 1'b1;
                r_d.fcode                  = fault_code;
                r_d.wrote                  = 1'b1;
                r_d.count                  = CW'(1);
                r_d.seq_next               = r_q.seq_next + SEQ_W'(1);
                r_d.state                  = THR_TRAP;
            end else begin
                r_d.valid = ch_emit;
                r_d.pc    = ch_pc;
                r_d.npc   = ch_npc;
                for (int k = 0; k < W; k++) begin
                    if (ch_emit[k]) begin
                        r_d.inst[k*INST_BITS +: INST_BITS] = picked[k*INST_BITS +: INST_BITS];
                        r_d.seq[k*SEQ_W +: SEQ_W] = r_q.seq_next + SEQ_W'(k);
                    end
                end
                r_d.wrote    = (ch_n != '0);
                r_d.count    = ch_n;
                r_d.seq_next = r_q.seq_next + SEQ_W'(ch_n);
                r_d.br       = r_q.br + CNT_W'(ch_nctrl);
                r_d.tk       = r_q.tk + CNT_W'(ch_ntaken);
                if (ch_n != '0) begin
                    r_d.upc  = ch_end;
                    r_d.unpc = ch_end + AW'(INST_BYTES);
                end
                if (ch_quiesce) begin
                    r_d.state = THR_QUIESCE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.upc      <= AW'(RESET_PC);
            r_q.unpc     <= AW'(RESET_PC) + AW'(INST_BYTES);
            r_q.state    <= THR_RUN;
        end else begin
            r_q <= r_d;
        end
    end

    assign slot_valid      = r_q.valid;
    assign slot_inst       = r_q.inst;
    assign slot_pc         = r_q.pc;
    assign slot_npc        = r_q.npc;
    assign slot_seq        = r_q.seq;
    assign slot_fault      = r_q.fault;
    assign slot_fault_code = r_q.fcode;
    assign wrote_out       = r_q.wrote;
    assign group_count     = r_q.count;
    assign upd_pc          = r_q.upc;
    assign upd_npc         = r_q.unpc;
    assign thr_state       = r_q.state;
    assign br_count        = r_q.br;
    assign taken_count     = r_q.tk;

endmodule

// File: rtl/line_inst_extractor_chk.sv
module line_inst_extractor_chk #(
    parameter int W     = 4,
    parameter int AW    = 32,
    parameter int SEQ_W = 16,
    parameter int CW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             restart,
    input logic             fetch_go,
    input logic [AW-1:0]    fetch_pc,
    input logic [AW-1:0]    line_addr,
    input logic [W-1:0]     slot_valid,
    input logic [W*AW-1:0]  slot_pc,
    input logic [W*AW-1:0]  slot_npc,
    input logic [W*SEQ_W-1:0] slot_seq,
    input logic             slot_fault,
    input logic             wrote_out,
    input logic [CW-1:0]    group_count,
    input logic [1:0]       thr_state
);

    always_comb begin
        assert_line_align_R2: assert (line_addr[5:0] == 6'd0 &&
                                      line_addr[AW-1:6] == fetch_pc[AW-1:6]);
    end

    assert_wrote_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wrote_out == (slot_valid != '0));

    assert_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(slot_valid) == int'(group_count) && int'(group_count) <= W);

    assert_fault_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slot_fault |-> (slot_valid == W'(1) && thr_state == 2'd2));

    assert_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_go |=> slot_valid == '0);

    assert_parked_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_state != 2'd0 || restart) |=> slot_valid == '0);

    assert_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> thr_state == 2'd0);

    genvar k;
    generate
        for (k = 1; k < W; k++) begin : g_pair
            assert_contig_R4: assert property (@(posedge clk) disable iff (!rst_n)
                slot_valid[k] |-> slot_valid[k-1]);
            assert_seq_R10: assert property (@(posedge clk) disable iff (!rst_n)
                slot_valid[k] |-> slot_seq[k*SEQ_W +: SEQ_W] ==
                                  slot_seq[(k-1)*SEQ_W +: SEQ_W] + SEQ_W'(1));
            assert_pc_link_R5: assert property (@(posedge clk) disable iff (!rst_n)
                slot_valid[k] |-> slot_pc[k*AW +: AW] == slot_npc[(k-1)*AW +: AW]);
        end
    endgenerate

endmodule

bind line_inst_extractor line_inst_extractor_chk #(
    .W(W), .AW(AW), .SEQ_W(SEQ_W), .CW(CW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (restart),
    .fetch_go    (fetch_go),
    .fetch_pc    (fetch_pc),
    .line_addr   (line_addr),
    .slot_valid  (slot_valid),
    .slot_pc     (slot_pc),
    .slot_npc    (slot_npc),
    .slot_seq    (slot_seq),
    .slot_fault  (slot_fault),
    .wrote_out   (wrote_out),
    .group_count (group_count),
    .thr_state   (thr_state)
);

// File: tb/test_line_inst_extractor.sv
`timescale 1ns/1ps
module test_line_inst_extractor;

    localparam int W = 4;
    localparam int AW = 32;
    localparam int SEQ_W = 16;
    localparam int CNT_W = 16;
    localparam int FW = 4;
    localparam int CW = $clog2(W + 1);
    localparam logic [31:0] NOP = 32'h0000_0013;
    localparam logic [31:0] RPC = 32'h0000_1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic restart = 1'b0;
    logic fetch_go = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic [511:0] line_data = '0;
    logic fault_valid = 1'b0;
    logic [FW-1:0] fault_code = '0;
    logic [W-1:0] pr_ctrl = '0, pr_taken = '0, pr_quiesce = '0;
    logic [W*AW-1:0] pr_target = '0;

    logic [AW-1:0] line_addr;
    logic [W-1:0] slot_valid;
    logic [W*32-1:0] slot_inst;
    logic [W*AW-1:0] slot_pc, slot_npc;
    logic [W*SEQ_W-1:0] slot_seq;
    logic slot_fault;
    logic [FW-1:0] slot_fault_code;
    logic wrote_out;
    logic [CW-1:0] group_count;
    logic [AW-1:0] upd_pc, upd_npc;
    logic [1:0] thr_state;
    logic [CNT_W-1:0] br_count, taken_count;

    always #2 clk = ~clk;

    line_inst_extractor #(.W(W), .AW(AW), .SEQ_W(SEQ_W), .CNT_W(CNT_W), .FW(FW),
                          .NOP_WORD(NOP), .RESET_PC(RPC)) i_line_inst_extractor (
        .clk, .rst_n, .restart, .fetch_go, .fetch_pc, .line_data, .fault_valid,
        .fault_code, .pr_ctrl, .pr_taken, .pr_target, .pr_quiesce, .line_addr,
        .slot_valid, .slot_inst, .slot_pc, .slot_npc, .slot_seq, .slot_fault,
        .slot_fault_code, .wrote_out, .group_count, .upd_pc, .upd_npc,
        .thr_state, .br_count, .taken_count);

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    int unsigned m_seq, m_br, m_tk, m_state, m_cnt;
    logic [AW-1:0] m_upc, m_unpc;
    logic [W-1:0] m_valid;
    logic [31:0] m_inst[W];
    logic [AW-1:0] m_pc[W], m_npc[W];
    int unsigned m_sq[W];
    logic m_fault;
    logic [FW-1:0] m_fcode;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_seq = 0; m_br = 0; m_tk = 0; m_state = 0; m_cnt = 0;
        m_upc = RPC; m_unpc = RPC + 4; m_valid = '0; m_fault = 0; m_fcode = '0;
    endtask

    // behavioural step from the inputs present at the clock edge
    task automatic model_step();
        int unsigned off;
        int k;
        bit stop;
        logic [AW-1:0] cur, nx;
        m_valid = '0; m_fault = 0; m_fcode = '0; m_cnt = 0;
        for (int i = 0; i < W; i++) begin
            m_inst[i] = '0; m_pc[i] = '0; m_npc[i] = '0; m_sq[i] = 0;
        end
        if (restart) begin
            m_state = 0;
        end else if (fetch_go && m_state == 0) begin
            cur = fetch_pc & ~32'd3;
            if (fault_valid) begin
                m_valid[0] = 1; m_inst[0] = NOP; m_pc[0] = cur; m_npc[0] = cur + 4;
                m_sq[0] = m_seq; m_seq++; m_fault = 1; m_fcode = fault_code;
                m_cnt = 1; m_state = 2;
            end else begin
                off = fetch_pc[5:2];
                k = 0; stop = 0;
                while (k < W && off + k < 16 && !stop) begin
                    m_valid[k] = 1;
                    m_inst[k] = line_data[(off + k) * 32 +: 32];
                    m_pc[k] = cur;
                    nx = pr_ctrl[k] ? pr_target[k*AW +: AW] : cur + 4;
                    m_npc[k] = nx;
                    m_sq[k] = m_seq; m_seq++;
                    if (pr_ctrl[k]) begin
                        m_br++;
                        if (pr_taken[k]) begin m_tk++; stop = 1; end
                    end
                    if (pr_quiesce[k]) begin stop = 1; m_state = 1; end
                    cur = nx;
                    k++;
                end
                m_cnt = k;
                if (k > 0) begin m_upc = cur; m_unpc = cur + 4; end
            end
        end
    endtask

    task automatic compare_all();
        check("R11 wrote_out", 64'(wrote_out), 64'(m_valid != 0));
        check("R4 group_count", 64'(group_count), 64'(m_cnt));
        check("R4 slot_valid", 64'(slot_valid), 64'(m_valid));
        check("R9 upd_pc", 64'(upd_pc), 64'(m_upc));
        check("R9 upd_npc", 64'(upd_npc), 64'(m_unpc));
        check("R12 thr_state", 64'(thr_state), 64'(m_state));
        check("R6 br_count", 64'(br_count), 64'(m_br % 65536));
        check("R6 taken_count", 64'(taken_count), 64'(m_tk % 65536));
        check("R8 slot_fault", 64'(slot_fault), 64'(m_fault));
        check("R8 slot_fault_code", 64'(slot_fault_code), 64'(m_fcode));
        for (int i = 0; i < W; i++) begin
            if (m_valid[i]) begin
                check("R3 slot_inst", 64'(slot_inst[i*32 +: 32]), 64'(m_inst[i]));
                check("R5 slot_pc", 64'(slot_pc[i*AW +: AW]), 64'(m_pc[i]));
                check("R6 slot_npc", 64'(slot_npc[i*AW +: AW]), 64'(m_npc[i]));
                check("R10 slot_seq", 64'(slot_seq[i*SEQ_W +: SEQ_W]), 64'(m_sq[i] % 65536));
            end
        end
    endtask

    // one clock: model at the edge, compare at the following falling edge
    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check("R2 line_addr", 64'(line_addr), 64'(fetch_pc & ~32'h3F));
        compare_all();
    endtask

    task automatic set_in(bit go, logic [AW-1:0] pc, logic [W-1:0] ctl,
                          logic [W-1:0] tk, logic [W-1:0] q);
        fetch_go = go; fetch_pc = pc; pr_ctrl = ctl; pr_taken = tk; pr_quiesce = q;
        fault_valid = 0; restart = 0;
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int j = 0; j < 16; j++) line_data[j*32 +: 32] = 32'hA500_0000 + 32'(j * 17);
        for (int i = 0; i < W; i++) pr_target[i*AW +: AW] = 32'h0000_8000 + 32'(i * 64);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        @(negedge clk);
        compare_all();
        check("R1 upd_pc reset", 64'(upd_pc), 64'(RPC));

        // R3/R5: offset 0, full width, plain words
        set_in(1, 32'h0000_2000, '0, '0, '0); step();
        // R13: idle cycle clears slots
        set_in(0, 32'h0000_2000, '0, '0, '0); step();
        // R3: unaligned PC low bits ignored, mid-line start
        set_in(1, 32'h0000_2017, '0, '0, '0); step();
        // R4: line end, 2 words left at offset 56
        set_in(1, 32'h0000_2038, '0, '0, '0); step();
        // R4: single word left
        set_in(1, 32'h0000_203C, '0, '0, '0); step();
        // R6: not-taken control uses target, following slot follows it
        set_in(1, 32'h0000_3000, 4'b0010, 4'b0000, '0); step();
        // R6: taken at slot 1 ends group
        set_in(1, 32'h0000_3000, 4'b0010, 4'b0010, '0); step();
        // R7: quiesce at slot 2
        set_in(1, 32'h0000_3100, '0, '0, 4'b0100); step();
        // R12: go ignored while quiescent
        set_in(1, 32'h0000_4000, '0, '0, '0); step();
        // R12: restart overrides go
        set_in(1, 32'h0000_4000, '0, '0, '0); restart = 1; step();
        set_in(1, 32'h0000_4004, '0, '0, '0); step();
        // R8: fault carrier, inputs ignored
        set_in(1, 32'h0000_5008, 4'b1111, 4'b1111, 4'b1111);
        fault_valid = 1; fault_code = 4'hB; step();
        set_in(1, 32'h0000_6000, '0, '0, '0); step();
        set_in(0, 32'h0000_6000, '0, '0, '0); restart = 1; step();
        // taken and quiesce in the same slot 0
        set_in(1, 32'h0000_7000, 4'b0001, 4'b0001, 4'b0001); step();
        set_in(0, 32'h0000_7000, '0, '0, '0); restart = 1; step();

        // R10: randomized traffic
        for (int c = 0; c < 2000; c++) begin
            fetch_go    = ($urandom % 4) != 0;
            fetch_pc    = $urandom;
            pr_ctrl     = W'($urandom);
            pr_taken    = W'($urandom);
            pr_quiesce  = (($urandom % 8) == 0) ? W'($urandom) : '0;
            fault_valid = ($urandom % 12) == 0;
            fault_code  = FW'($urandom);
            restart     = ($urandom % 6) == 0;
            for (int i = 0; i < W; i++) pr_target[i*AW +: AW] = $urandom;
            for (int j = 0; j < 16; j++) line_data[j*32 +: 32] = $urandom;
            step();
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule